// File: doc/BRIEF.md
# USB Host OUT Transaction Retry Controller

This block holds the retry policy for one host-side OUT endpoint. A packet in the transmit FIFO becomes ready in one of two ways: software or a DMA engine pulses a ready-set input, or, with automatic mode on, the FIFO byte count reaches the configured maximum packet size. While a packet is ready and no attempt is outstanding, the block offers a request to the transaction scheduler over a valid/ready handshake. `req_valid` stays high until the scheduler takes it with `req_ready`. After an accepted request, no new request is offered until the result of that attempt comes back.

Each attempt ends with a response code on `rsp_valid`/`rsp_code`. The response path has no back-pressure: the block takes a response in the cycle it is valid. The block sorts replies into three retry classes, each with its own limit and status outcome:

- **Handshake refusals (NAK)** are retried up to a programmable limit.
- **A stall** ends the packet at once.
- **Silence or a corrupted reply** is retried up to three times in a row. After that the FIFO is flushed.

Status flags are sticky and are cleared by writing one. An interrupt line is the OR of the flags.

Top module: `usb_out_retry_ctrl`

## Requirements
- R1: `req_valid` is high only while a packet is ready and no attempt is in flight. It holds until `req_ready` is seen. After an accepted request it stays low until a response code of 0 to 4 is taken.
- R2: A pulse on `sw_ready_set` while no packet is ready and none is in flight makes `pkt_ready` high after the next edge. A pulse while a packet is already ready is ignored and does not restart the retry counts.
- R3: With `cfg_auto_ready` high, `pkt_ready` is set once `fifo_count >= cfg_max_pkt`. With `cfg_auto_ready` low, or with the count below the maximum, the fill level sets nothing.
- R4: Response codes are: 0 ACK, 1 NAK, 2 STALL, 3 no reply, 4 CRC or bit-stuff error. An ACK clears `pkt_ready`, clears both retry counts, and pulses `tx_done` for one cycle.
- R5: A NAK leaves the packet ready for another attempt. The NAK that brings the count to a nonzero `cfg_nak_limit` clears `pkt_ready` and sets `sts_nak_timeout` (status bit 2).
- R6: With `cfg_nak_limit` at zero, NAKs are retried without end and never set `sts_nak_timeout`.
- R7: A STALL is not retried. It clears `pkt_ready` and sets `sts_stalled` (status bit 0).
- R8: Codes 3 and 4 are retried. The third one in a row pulses `fifo_flush` for one cycle, sets `sts_error` (status bit 1) and clears `pkt_ready`. A NAK between them neither counts toward the three nor resets the count.
- R9: The no-reply/corrupt count restarts on an ACK and when a new packet becomes ready.
- R10: Status flags stay set until a one is written to their bit of `clr_status` (bit 0 stalled, bit 1 error, bit 2 NAK timeout). A set and a clear in the same cycle leave the flag set. `irq` is high while any flag is set.
- R11: A response taken while no attempt is in flight, or a response with a code of 5 to 7, changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_auto_ready | input | 1 | Enable ready-on-fill |
| cfg_max_pkt | input | CNT_W | Maximum packet size in bytes |
| cfg_nak_limit | input | NAK_W | NAK attempts before timeout; 0 disables the timeout |
| fifo_count | input | CNT_W | Bytes held in the transmit FIFO |
| sw_ready_set | input | 1 | Pulse: packet loaded and ready |
| req_valid | output | 1 | Attempt request to the scheduler |
| req_ready | input | 1 | Scheduler accepts the request |
| rsp_valid | input | 1 | Attempt result present |
| rsp_code | input | 3 | Attempt result code |
| pkt_ready | output | 1 | Packet-ready flag |
| tx_done | output | 1 | One-cycle pulse on ACK |
| fifo_flush | output | 1 | One-cycle pulse to empty the FIFO |
| clr_status | input | 3 | Write-one-to-clear for the status flags |
| sts_stalled | output | 1 | Sticky stall flag |
| sts_error | output | 1 | Sticky retry-exhausted flag |
| sts_nak_timeout | output | 1 | Sticky NAK-timeout flag |
| irq | output | 1 | Any status flag set |

## Verification
Every result is registered on the edge that samples its cause. Ready, status, flush and done therefore appear one edge after the ready-set pulse, fill level or response. The request line follows `pkt_ready` and the in-flight state with no extra delay. The bench changes inputs at the falling edge, lets exactly one rising edge pass, and samples at the next falling edge. One-cycle pulses are therefore seen in their only cycle, and checked low one cycle later. Sequences of several attempts are stepped one handshake at a time, so the edge on which each count advances is known.

// File: rtl/usb_retry_pkg.sv
package usb_retry_pkg;
  typedef enum logic [2:0] {
    RSP_ACK    = 3'd0,
    RSP_NAK    = 3'd1,
    RSP_STALL  = 3'd2,
    RSP_NORESP = 3'd3,
    RSP_CORRUPT = 3'd4
  } rsp_e;

  localparam int ST_STALL = 0;
  localparam int ST_ERROR = 1;
  localparam int ST_NAKTO = 2;
  localparam int ST_NUM   = 3;
endpackage

// File: rtl/uor_ready_ctrl.sv
module uor_ready_ctrl #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_set,
  input  logic             auto_en,
  input  logic [CNT_W-1:0] fill,
  input  logic [CNT_W-1:0] max_pkt,
  input  logic             accept,
  input  logic             rsp_take,
  input  logic             release_pkt,
  output logic             pkt_ready,
  output logic             busy,
  output logic             load
);
  logic fill_hit;

  assign fill_hit = auto_en && (fill >= max_pkt);
  // a new packet is only taken when the slot is empty and idle
  assign load = !pkt_ready && !busy && (sw_set || fill_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pkt_ready <= 1'b0;
    end else if (release_pkt) begin
      pkt_ready <= 1'b0;
    end else if (load) begin
      pkt_ready <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
    end else if (accept) begin
      busy <= 1'b1;
    end else if (rsp_take) begin
      busy <= 1'b0;
    end
  end
endmodule

// File: rtl/uor_retry_cnt.sv
module uor_retry_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  input  logic [W-1:0] limit,
  input  logic         limit_en,
  output logic         hit
);
  logic [W-1:0] cnt;
  logic [W-1:0] cnt_nxt;

  assign cnt_nxt = cnt + 1'b1;
  assign hit     = inc && limit_en && (cnt_nxt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr || hit) begin
      cnt <= '0;
    end else if (inc) begin
      cnt <= cnt_nxt;
    end
  end
endmodule

// File: rtl/uor_status.sv
module uor_status #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flags[i] <= 1'b0;
      end else if (set[i]) begin
        flags[i] <= 1'b1;
      end else if (clr[i]) begin
        flags[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/usb_out_retry_ctrl.sv
module usb_out_retry_ctrl
  import usb_retry_pkg::*;
#(
  parameter int CNT_W     = 11,
  parameter int NAK_W     = 8,
  parameter int ERR_TRIES = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_auto_ready,
  input  logic [CNT_W-1:0] cfg_max_pkt,
  input  logic [NAK_W-1:0] cfg_nak_limit,
  input  logic [CNT_W-1:0] fifo_count,
  input  logic             sw_ready_set,
  output logic             req_valid,
  input  logic             req_ready,
  input  logic             rsp_valid,
  input  logic [2:0]       rsp_code,
  output logic             pkt_ready,
  output logic             tx_done,
  output logic             fifo_flush,
  input  logic [2:0]       clr_status,
  output logic             sts_stalled,
  output logic             sts_error,
  output logic             sts_nak_timeout,
  output logic             irq
);
  localparam int ERR_W = $clog2(ERR_TRIES + 1);
  localparam logic [ERR_W-1:0] ERR_LIM = ERR_W'(ERR_TRIES);

  logic busy, load, accept, rsp_take, known;
  logic is_ack, is_nak, is_stall, is_err;
  logic nak_hit, err_hit, cnt_clr, release_pkt;
  logic [ST_NUM-1:0] st_set, st_flags;
  rsp_e code;

  assign code   = rsp_e'(rsp_code);
  assign known  = (rsp_code <= 3'd4);
  assign is_ack   = (code == RSP_ACK);
  assign is_nak   = (code == RSP_NAK);
  assign is_stall = (code == RSP_STALL);
  assign is_err   = (code == RSP_NORESP) || (code == RSP_CORRUPT);

  assign req_valid = pkt_ready && !busy;
  assign accept    = req_valid && req_ready;
  assign rsp_take  = rsp_valid && busy && known;

  assign cnt_clr     = load || (rsp_take && (is_ack || is_stall));
  assign release_pkt = rsp_take && (is_ack || is_stall || nak_hit || err_hit);

  uor_ready_ctrl #(.CNT_W(CNT_W)) u_ready (
    .clk(clk), .rst_n(rst_n),
    .sw_set(sw_ready_set), .auto_en(cfg_auto_ready),
    .fill(fifo_count), .max_pkt(cfg_max_pkt),
    .accept(accept), .rsp_take(rsp_take), .release_pkt(release_pkt),
    .pkt_ready(pkt_ready), .busy(busy), .load(load)
  );

  uor_retry_cnt #(.W(NAK_W)) u_nak_cnt (
    .clk(clk), .rst_n(rst_n),
    .clr(cnt_clr), .inc(rsp_take && is_nak),
    .limit(cfg_nak_limit), .limit_en(cfg_nak_limit != '0),
    .hit(nak_hit)
  );

  uor_retry_cnt #(.W(ERR_W)) u_err_cnt (
    .clk(clk), .rst_n(rst_n),
    .clr(cnt_clr), .inc(rsp_take && is_err),
    .limit(ERR_LIM), .limit_en(1'b1),
    .hit(err_hit)
  );

  always_comb begin
    st_set           = '0;
    st_set[ST_STALL] = rsp_take && is_stall;
    st_set[ST_ERROR] = err_hit;
    st_set[ST_NAKTO] = nak_hit;
  end

  uor_status #(.N(ST_NUM)) u_status (
    .clk(clk), .rst_n(rst_n),
    .set(st_set), .clr(clr_status), .flags(st_flags)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_done    <= 1'b0;
      fifo_flush <= 1'b0;
    end else begin
      tx_done    <= rsp_take && is_ack;
      fifo_flush <= err_hit;
    end
  end

  assign sts_stalled     = st_flags[ST_STALL];
  assign sts_error       = st_flags[ST_ERROR];
  assign sts_nak_timeout = st_flags[ST_NAKTO];
  assign irq             = |st_flags;
endmodule

// File: rtl/usb_out_retry_ctrl_chk.sv
module usb_out_retry_ctrl_chk #(
  parameter int NAK_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic [2:0]       rsp_code,
  input logic             busy,
  input logic             pkt_ready,
  input logic             tx_done,
  input logic             fifo_flush,
  input logic [2:0]       clr_status,
  input logic [NAK_W-1:0] cfg_nak_limit,
  input logic             sts_stalled,
  input logic             sts_error,
  input logic             sts_nak_timeout
);
  AST_REQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (pkt_ready && !busy)); // R1
  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (busy && !req_valid)); // R1
  AST_ACK_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && busy && rsp_code == 3'd0) |=> (tx_done && !pkt_ready)); // R4
  AST_NAK_UNLIMITED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_nak_limit == '0 && !sts_nak_timeout) |=> !sts_nak_timeout); // R6
  AST_STALL_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && busy && rsp_code == 3'd2) |=> (sts_stalled && !pkt_ready)); // R7
  AST_FLUSH_WITH_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_flush |-> (sts_error && !pkt_ready)); // R8
  AST_FLUSH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_flush |=> !fifo_flush); // R8
  AST_STICKY_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_error && !clr_status[1]) |=> sts_error); // R10
  AST_IDLE_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !busy && clr_status == 3'b000)
      |=> $stable({sts_stalled, sts_error, sts_nak_timeout})); // R11
endmodule

bind usb_out_retry_ctrl usb_out_retry_ctrl_chk #(.NAK_W(NAK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_code(rsp_code), .busy(busy),
  .pkt_ready(pkt_ready), .tx_done(tx_done), .fifo_flush(fifo_flush),
  .clr_status(clr_status), .cfg_nak_limit(cfg_nak_limit),
  .sts_stalled(sts_stalled), .sts_error(sts_error),
  .sts_nak_timeout(sts_nak_timeout)
);

// File: tb/usb_out_retry_ctrl_test.sv
module usb_out_retry_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_auto_ready = 1'b0;
  logic [10:0] cfg_max_pkt = 11'd64;
  logic [7:0]  cfg_nak_limit = 8'd4;
  logic [10:0] fifo_count = '0;
  logic        sw_ready_set = 1'b0;
  logic        req_ready = 1'b0;
  logic        rsp_valid = 1'b0;
  logic [2:0]  rsp_code = 3'd0;
  logic [2:0]  clr_status = 3'b000;
  logic req_valid, pkt_ready, tx_done, fifo_flush;
  logic sts_stalled, sts_error, sts_nak_timeout, irq;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  usb_out_retry_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cfg_auto_ready(cfg_auto_ready),
    .cfg_max_pkt(cfg_max_pkt), .cfg_nak_limit(cfg_nak_limit),
    .fifo_count(fifo_count), .sw_ready_set(sw_ready_set),
    .req_valid(req_valid), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_code(rsp_code), .pkt_ready(pkt_ready), .tx_done(tx_done),
    .fifo_flush(fifo_flush), .clr_status(clr_status),
    .sts_stalled(sts_stalled), .sts_error(sts_error),
    .sts_nak_timeout(sts_nak_timeout), .irq(irq)
  );

  // limit[22:15] pre_n[14:11] pre_code[10:8] code[7:5] ready[4] sts{nak,err,stall}[3:1] flush[0]
  localparam int NV = 10;
  localparam logic [22:0] VEC [NV] = '{
    {8'd4, 4'd0, 3'd0, 3'd0, 1'b0, 3'b000, 1'b0},  // R4 ack
    {8'd4, 4'd0, 3'd0, 3'd1, 1'b1, 3'b000, 1'b0},  // R5 one nak retries
    {8'd4, 4'd3, 3'd1, 3'd1, 1'b0, 3'b100, 1'b0},  // R5 fourth nak times out
    {8'd0, 4'd9, 3'd1, 3'd1, 1'b1, 3'b000, 1'b0},  // R6 unlimited
    {8'd4, 4'd0, 3'd0, 3'd2, 1'b0, 3'b001, 1'b0},  // R7 stall
    {8'd4, 4'd1, 3'd3, 3'd4, 1'b1, 3'b000, 1'b0},  // R8 two errors retry
    {8'd4, 4'd2, 3'd3, 3'd4, 1'b0, 3'b010, 1'b1},  // R8 third error flushes
    {8'd1, 4'd0, 3'd0, 3'd1, 1'b0, 3'b100, 1'b0},  // R5 limit of one
    {8'd4, 4'd2, 3'd4, 3'd0, 1'b0, 3'b000, 1'b0},  // R4 ack after errors
    {8'd4, 4'd2, 3'd1, 3'd3, 1'b1, 3'b000, 1'b0}   // R8 naks not counted
  };

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic mark_ready();
    sw_ready_set = 1'b1;
    @(negedge clk);
    sw_ready_set = 1'b0;
  endtask

  task automatic attempt(input logic [2:0] c);
    for (int w = 0; w < 50 && !req_valid; w++) @(negedge clk);
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
    rsp_valid = 1'b1;
    rsp_code  = c;
    @(negedge clk);
    rsp_valid = 1'b0;
  endtask

  function automatic int sts3();
    return {29'd0, sts_nak_timeout, sts_error, sts_stalled};
  endfunction

  initial begin
    #(8 * 100000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // reset state
    check("R1 reset req_valid", int'(req_valid), 0);
    check("R2 reset pkt_ready", int'(pkt_ready), 0);
    check("R10 reset status", sts3(), 0);
    check("R10 reset irq", int'(irq), 0);
    check("R8 reset flush", int'(fifo_flush), 0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      do_reset();
      cfg_nak_limit = VEC[i][22:15];
      mark_ready();
      for (int p = 0; p < int'(VEC[i][14:11]); p++) attempt(VEC[i][10:8]);
      attempt(VEC[i][7:5]);
      check($sformatf("R4-R8 vec%0d ready", i), int'(pkt_ready), int'(VEC[i][4]));
      check($sformatf("R4-R8 vec%0d status", i), sts3(), int'(VEC[i][3:1]));
      check($sformatf("R8 vec%0d flush", i), int'(fifo_flush), int'(VEC[i][0]));
      check($sformatf("R10 vec%0d irq", i), int'(irq), int'(VEC[i][3:1] != 3'b000));
    end
    cfg_nak_limit = 8'd4;

    // R1 hold, single in flight, unknown code; R4 done pulse
    do_reset();
    mark_ready();
    repeat (3) @(negedge clk);
    check("R1 req held", int'(req_valid), 1);
    req_ready = 1'b1; @(negedge clk); req_ready = 1'b0;
    check("R1 no req in flight", int'(req_valid), 0);
    rsp_valid = 1'b1; rsp_code = 3'd6; @(negedge clk); rsp_valid = 1'b0;
    check("R11 unknown code keeps flight", int'(req_valid), 0);
    check("R11 unknown code keeps ready", int'(pkt_ready), 1);
    rsp_valid = 1'b1; rsp_code = 3'd0; @(negedge clk); rsp_valid = 1'b0;
    check("R4 done pulse", int'(tx_done), 1);
    @(negedge clk);
    check("R4 done one cycle", int'(tx_done), 0);

    // R11 response with nothing in flight
    do_reset();
    mark_ready();
    rsp_valid = 1'b1; rsp_code = 3'd2; @(negedge clk); rsp_valid = 1'b0;
    check("R11 idle stall ignored", int'(sts_stalled), 0);
    check("R11 idle stall keeps ready", int'(pkt_ready), 1);

    // R2 re-mark while ready does not reset the error count
    do_reset();
    mark_ready();
    attempt(3'd3); attempt(3'd3);
    mark_ready();
    attempt(3'd4);
    check("R2 remark ignored error", int'(sts_error), 1);
    check("R2 remark ignored flush", int'(fifo_flush), 1);
    @(negedge clk);
    check("R8 flush one cycle", int'(fifo_flush), 0);

    // R9 ack restarts the error count
    do_reset();
    mark_ready();
    attempt(3'd3); attempt(3'd3); attempt(3'd0);
    mark_ready();
    attempt(3'd3); attempt(3'd4);
    check("R9 count restarted", int'(sts_error), 0);
    check("R9 still ready", int'(pkt_ready), 1);

    // R10 sticky and write-one-to-clear per bit
    do_reset();
    mark_ready();
    attempt(3'd2);
    clr_status = 3'b010; @(negedge clk); clr_status = 3'b000;
    check("R10 other bit clear keeps", int'(sts_stalled), 1);
    clr_status = 3'b001; @(negedge clk); clr_status = 3'b000;
    check("R10 own bit clears", int'(sts_stalled), 0);
    check("R10 irq drops", int'(irq), 0);

    // R3 auto-ready from fill level
    do_reset();
    cfg_max_pkt = 11'd64;
    fifo_count = 11'd64; cfg_auto_ready = 1'b0; @(negedge clk);
    check("R3 auto off", int'(pkt_ready), 0);
    fifo_count = 11'd63; cfg_auto_ready = 1'b1; @(negedge clk);
    check("R3 below max", int'(pkt_ready), 0);
    fifo_count = 11'd64; @(negedge clk);
    check("R3 at max", int'(pkt_ready), 1);
    check("R1 auto request", int'(req_valid), 1);
    cfg_auto_ready = 1'b0; fifo_count = '0;

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule